// File: doc/BRIEF.md
# Variable-Length Synchronous Serial Master

This block is a register-driven master for short synchronous serial exchanges with slow peripherals such as touch-panel converters and audio codecs. Software first programs a setup register that picks the device-select code, the serial clock rate and the sampling edge. It then writes a single packed control word. That word carries the command length, the total frame length and a command that is left-justified in its upper half. Setting the enable bit in the same write launches one frame.

During a frame the master sends the command bits most significant first and drives the data line low for the remaining bit clocks. Throughout the frame it shifts in the slave's reply. When the last bit clock finishes, busy drops, an end-of-transfer interrupt flag rises, and the received frame can be read back right-aligned.

Top module: `ssm_serial_master`

## Requirements
- R1: After synchronous reset: busy is 0, the interrupt flag is 0, `cs_code` is 7 (no device), `sclk` and `mosi` are 0, and the data register reads 0.
- R2: Control word written at address 0. Command length is in bits [4:0]. Frame length is in bits [11:7]. The enable bit is bit 12. The command sits in bits [31:16] and is sent starting from bit 31. A write while idle stores the word, which reads back at address 3 with bit 12 as 0. The write starts a frame only when bit 12 is 1.
- R3: Command length is clamped to 4..16 and frame length is clamped to 4..24. A value below the range acts as the minimum and a value above it acts as the maximum.
- R4: Busy rises on the clock edge that accepts a starting write. It stays high for exactly frame_len × 2 × H cycles. Each bit clock is H cycles in the inactive phase followed by H cycles in the sampling phase.
- R5: `mosi` carries the command bits, most significant first, for the first min(cmd_len, frame_len) bit clocks. It is 0 for the rest of the frame and 0 while idle.
- R6: `miso` is sampled at the edge that enters each bit's sampling phase. When a frame ends, address 0 reads the frame right-aligned: the first received bit is in bit frame_len−1, and all higher bits are 0.
- R7: The interrupt flag `eot_irq` rises on the edge that ends a frame. A read strobe at address 0 clears it. If the clear and a frame end fall on the same edge, the flag is set.
- R8: Setup bit 3 selects falling-edge sampling. When it is set, `sclk` idles high and is inverted during the frame, so the sampling edge is a falling edge. When it is clear, `sclk` idles low and the sampling edge is a rising edge.
- R9: Setup bits [5:4] select the rate: H = HALF_MIN << (3 − rate). Rate 3 is the fastest and rate 0 the slowest.
- R10: Setup bits [2:0] drive `cs_code` (write at address 1, read back at address 1). Writes to either the setup or the control register while busy are ignored.
- R11: Address 2 reads status: bit 0 is busy and bit 1 is the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt flag at address 0) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| busy | output | 1 | Frame in progress |
| eot_irq | output | 1 | End-of-transfer interrupt flag |
| cs_code | output | 3 | Device-select code, 7 = none |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A corrupted bit counter or phase counter shows at the ports within one bit clock: `sclk` toggles at the wrong cycle, or busy falls early or late. A reference that follows every cycle catches either case on the first wrong edge. A corrupted command shift register shows on `mosi` in the very bit where it goes wrong. A fault in the receive register stays hidden until the frame ends and address 0 is read, at the latest frame_len × 2 × H cycles later. Faults in the flag and the setup register show on `eot_irq`, `cs_code` or the status read in the cycle after the edge that should have set them.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int CMD_W      = 16;
    localparam int FRAME_MAX  = 24;
    localparam int LEN_W      = 5;
    localparam int CMD_MIN    = 4;
    localparam int FRAME_MIN  = 4;
    localparam int EN_BIT     = 12;
    localparam logic [2:0] CS_NONE = 3'd7;

    typedef enum logic [1:0] {
        A_DATA  = 2'd0,
        A_SETUP = 2'd1,
        A_STAT  = 2'd2,
        A_CTRL  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [LEN_W-1:0] frame_len;
        logic [LEN_W-1:0] cmd_len;
    } xfer_cfg_t;

    typedef struct packed {
        logic [1:0] rate;
        logic       fall_edge;
        logic [2:0] cs;
    } bus_cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v,
                                                   input logic [LEN_W-1:0] lo,
                                                   input logic [LEN_W-1:0] hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic xfer_cfg_t decode_ctrl(input logic [31:0] w);
        xfer_cfg_t c;
        c.cmd       = w[31:32-CMD_W];
        c.frame_len = clamp_len(w[11:7], LEN_W'(FRAME_MIN), LEN_W'(FRAME_MAX));
        c.cmd_len   = clamp_len(w[4:0], LEN_W'(CMD_MIN), LEN_W'(CMD_W));
        return c;
    endfunction

endpackage

// File: rtl/ssm_rate_timer.sv
module ssm_rate_timer #(
    parameter int HALF_MIN = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       phase,
    output logic       rise_tick,
    output logic       fall_tick
);
    localparam int HALF_MAX = HALF_MIN * 8;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;
    logic             wrap;

    always_comb begin
        half = CNT_W'(HALF_MIN) << (2'd3 - rate);
        wrap = (cnt == half - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (run) begin
            if (wrap) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rise_tick = run && wrap && !phase;
    assign fall_tick = run && wrap &&  phase;

endmodule

// File: rtl/ssm_shift_core.sv
module ssm_shift_core
    import ssm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  xfer_cfg_t            cfg_in,
    input  logic                 run,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 miso,
    output logic                 mosi,
    output logic                 last_bit,
    output logic [FRAME_MAX-1:0] rx_word
);
    logic [CMD_W-1:0] cmd_sh;
    logic [LEN_W-1:0] bit_idx;
    logic [LEN_W-1:0] cmd_len;
    logic [LEN_W-1:0] frame_len;

    assign mosi     = run && (bit_idx < cmd_len) ? cmd_sh[CMD_W-1] : 1'b0;
    assign last_bit = (bit_idx == frame_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sh    <= '0;
            bit_idx   <= '0;
            cmd_len   <= '0;
            frame_len <= '0;
            rx_word   <= '0;
        end else if (load) begin
            cmd_sh    <= cfg_in.cmd;
            cmd_len   <= cfg_in.cmd_len;
            frame_len <= cfg_in.frame_len;
            bit_idx   <= '0;
            rx_word   <= '0;
        end else begin
            if (rise_tick)
                rx_word <= {rx_word[FRAME_MAX-2:0], miso};
            if (fall_tick) begin
                bit_idx <= bit_idx + 1'b1;
                cmd_sh  <= cmd_sh << 1;
            end
        end
    end

endmodule

// File: rtl/ssm_serial_master.sv
module ssm_serial_master
    import ssm_pkg::*;
#(
    parameter int HALF_MIN = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        eot_irq,
    output logic [2:0]  cs_code,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso
);
    bus_cfg_t             setup_q;
    logic [31:0]          ctrl_q;
    logic                 busy_q;
    logic                 irq_q;
    logic [FRAME_MAX-1:0] data_q;

    logic                 wr_ctrl, wr_setup, rd_data, start, done;
    logic                 phase, rise_tick, fall_tick, last_bit;
    logic [FRAME_MAX-1:0] rx_word;
    xfer_cfg_t            new_cfg;

    assign wr_ctrl  = reg_wr && (reg_addr == 2'(A_DATA)) && !busy_q;
    assign wr_setup = reg_wr && (reg_addr == 2'(A_SETUP)) && !busy_q;
    assign rd_data  = reg_rd && (reg_addr == 2'(A_DATA));
    assign start    = wr_ctrl && reg_wdata[EN_BIT];
    assign done     = fall_tick && last_bit;
    assign new_cfg  = decode_ctrl(reg_wdata);

    ssm_rate_timer #(.HALF_MIN(HALF_MIN)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .restart   (start),
        .run       (busy_q),
        .rate      (setup_q.rate),
        .phase     (phase),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    ssm_shift_core shift_i (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .cfg_in    (new_cfg),
        .run       (busy_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .miso      (miso),
        .mosi      (mosi),
        .last_bit  (last_bit),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '{rate: 2'd0, fall_edge: 1'b0, cs: CS_NONE};
            ctrl_q  <= '0;
            busy_q  <= 1'b0;
            irq_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= reg_wdata & ~(32'd1 << EN_BIT);
            if (wr_setup)
                setup_q <= bus_cfg_t'(reg_wdata[5:0]);
            if (start) begin
                busy_q <= 1'b1;
            end else if (done) begin
                busy_q <= 1'b0;
                data_q <= rx_word;
            end
            if (done)
                irq_q <= 1'b1;
            else if (rd_data)
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            2'(A_DATA):  reg_rdata = {{(32-FRAME_MAX){1'b0}}, data_q};
            2'(A_SETUP): reg_rdata = {26'd0, setup_q};
            2'(A_STAT):  reg_rdata = {30'd0, irq_q, busy_q};
            default:     reg_rdata = ctrl_q;
        endcase
    end

    assign busy    = busy_q;
    assign eot_irq = irq_q;
    assign cs_code = setup_q.cs;
    assign sclk    = busy_q ? (phase ^ setup_q.fall_edge) : setup_q.fall_edge;

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        busy,
    input logic        eot_irq,
    input logic [2:0]  cs_code,
    input logic        sclk,
    input logic        mosi
);
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr && reg_addr == 2'd0 && reg_wdata[12])); // R2

    AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mosi); // R5

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> eot_irq); // R7

    AST_SCLK_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && !$past(reg_wr)) |-> $stable(sclk)); // R8

    AST_CS_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cs_code)); // R10

endmodule

bind ssm_serial_master ssm_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .eot_irq   (eot_irq),
    .cs_code   (cs_code),
    .sclk      (sclk),
    .mosi      (mosi)
);

// File: tb/ssm_serial_master_tb_top.sv
`timescale 1ns/1ps
module ssm_serial_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        busy, eot_irq, sclk, mosi;
    logic [2:0]  cs_code;
    logic        miso = 1'b0;

    always #2 clk = ~clk;

    ssm_serial_master dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .eot_irq(eot_irq), .cs_code(cs_code),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [23:0] slv_word = 24'd0;

    // behavioural reference
    bit          m_busy, m_irq, m_fe;
    int          m_t, m_h, m_cl, m_fl, m_rate, m_cs;
    logic [15:0] m_cmd;
    logic [23:0] m_rx, m_data;
    logic [31:0] m_ctrl;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int clampi(int v, int lo, int hi);
        return v < lo ? lo : (v > hi ? hi : v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_irq = 0; m_fe = 0; m_t = 0; m_h = 8; m_cl = 4; m_fl = 4;
            m_rate = 0; m_cs = 7; m_cmd = 0; m_rx = 0; m_data = 0; m_ctrl = 0;
        end else begin
            bit was, fin;
            was = m_busy;
            fin = m_busy && (m_t == m_fl * 2 * m_h - 1);
            if (m_busy && (m_t % (2 * m_h)) == m_h - 1)
                m_rx = {m_rx[22:0], miso};
            if (reg_rd && reg_addr == 2'd0) m_irq = 0;
            if (fin) begin
                m_busy = 0; m_irq = 1; m_data = m_rx;
            end else if (m_busy) m_t++;
            if (reg_wr && !was) begin
                if (reg_addr == 2'd0) begin
                    m_ctrl = reg_wdata & ~(32'd1 << 12);
                    if (reg_wdata[12]) begin
                        m_busy = 1; m_t = 0; m_rx = 0;
                        m_cmd = reg_wdata[31:16];
                        m_cl = clampi(int'(reg_wdata[4:0]), 4, 16);
                        m_fl = clampi(int'(reg_wdata[11:7]), 4, 24);
                        m_h = 1 << (3 - m_rate);
                    end
                end else if (reg_addr == 2'd1) begin
                    m_cs = int'(reg_wdata[2:0]);
                    m_fe = reg_wdata[3];
                    m_rate = int'(reg_wdata[5:4]);
                end
            end
        end
    end

    // per-cycle comparison, then slave drives its next bit
    always @(negedge clk) begin
        int two, b;
        logic e_sclk, e_mosi;
        logic [31:0] e_rd;
        if (!rst) begin
            two = 2 * m_h;
            b = m_t / two;
            e_sclk = m_busy ? (((m_t % two) >= m_h) ^ m_fe) : m_fe;
            e_mosi = (m_busy && b < m_cl) ? m_cmd[15 - b] : 1'b0;
            chk("R4", "busy", busy, m_busy);
            chk("R8 R9", "sclk", sclk, e_sclk);
            chk("R5", "mosi", mosi, e_mosi);
            chk("R7", "eot_irq", eot_irq, m_irq);
            chk("R10", "cs_code", cs_code, m_cs);
            case (reg_addr)
                2'd0: e_rd = {8'd0, m_data};
                2'd1: e_rd = {26'd0, 2'(m_rate), m_fe, 3'(m_cs)};
                2'd2: e_rd = {30'd0, m_irq, m_busy};
                default: e_rd = m_ctrl;
            endcase
            case (reg_addr)
                2'd0: chk("R6", "rdata data", reg_rdata, e_rd);
                2'd1: chk("R10", "rdata setup", reg_rdata, e_rd);
                2'd2: chk("R11", "rdata status", reg_rdata, e_rd);
                default: chk("R2", "rdata ctrl", reg_rdata, e_rd);
            endcase
            miso = m_busy ? slv_word[m_fl - 1 - b] : 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] mk(logic [15:0] c, int cl, int fl, bit en);
        return {c, 3'd0, en, 5'(fl), 2'd0, 5'(cl)};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); #1;
        reg_rd = 1; reg_addr = a;
        @(negedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic xfer(input logic [31:0] w, input int exp_cycles, input string tag);
        int n;
        wr(2'd0, w);
        n = 1;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk(tag, "busy length", n, exp_cycles);
        rd(2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset irq", eot_irq, 0);
        chk("R1", "reset cs", cs_code, 7);
        chk("R1", "reset sclk", sclk, 0);
        chk("R1", "reset mosi", mosi, 0);
        chk("R1", "reset data", reg_rdata, 0);
        #1 rst = 0;

        wr(2'd1, 32'h32);                       // rate 3, rising, cs 2
        wr(2'd0, mk(16'hA5C3, 8, 12, 0));       // fields only
        @(negedge clk); #1 reg_addr = 2'd3;
        @(negedge clk);
        chk("R2", "stored ctrl", reg_rdata, mk(16'hA5C3, 8, 12, 0));
        chk("R2", "no start", busy, 0);

        slv_word = 24'h5A3C96;
        xfer(mk(16'hA5C3, 8, 12, 1), 24, "R4");
        @(negedge clk); #1 reg_addr = 2'd2;
        @(negedge clk);
        chk("R7", "status irq after read", reg_rdata[1], 0);

        wr(2'd1, 32'h2D);                       // rate 2, falling, cs 5
        slv_word = 24'hC3A55A;
        wr(2'd0, mk(16'hF00F, 16, 24, 1));
        wr(2'd1, 32'h07);                       // ignored while busy
        wr(2'd0, mk(16'h1234, 4, 4, 1));        // ignored while busy
        @(negedge clk);
        chk("R10", "cs held while busy", cs_code, 5);
        #1 reg_addr = 2'd0;
        while (busy) @(negedge clk);
        @(negedge clk); #1 reg_addr = 2'd2;
        @(negedge clk);
        chk("R7", "status irq set", reg_rdata[1], 1);
        chk("R11", "status busy low", reg_rdata[0], 0);
        rd(2'd0);

        wr(2'd1, 32'h31);                       // rate 3, rising, cs 1
        slv_word = 24'h9E3779;
        xfer(mk(16'h8001, 2, 30, 1), 48, "R3");
        slv_word = 24'h00000B;
        xfer(mk(16'hB7E1, 31, 1, 1), 8, "R3");

        wr(2'd1, 32'h00);                       // rate 0, rising, cs 0
        slv_word = 24'h000015;
        xfer(mk(16'h6000, 4, 5, 1), 80, "R9");

        // read strobe held across the frame end
        wr(2'd1, 32'h3B);
        slv_word = 24'h000F0F;
        wr(2'd0, mk(16'hCAFE, 12, 16, 1));
        @(negedge clk); #1 reg_rd = 1; reg_addr = 2'd0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        #1 reg_rd = 0;
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule